// File: doc/BRIEF.md
# I/O Wait-State and Composite Select Controller

This block sits between a processor core's external strobes and slow peripherals. When the core starts an access to I/O space, the block takes the 11-bit I/O address and decodes it into one of four equal regions of 512 words each. It reads that region's 3-bit wait setting and converts it to a wait-cycle count. It then holds a ready line low for that many cycles and ends the access with a one-cycle acknowledge. A global mode bit selects how the 3-bit setting is turned into a count. In the direct mapping a setting of n gives n cycles. In the stretched mapping it gives 2n+1 cycles, which reaches the maximum of 15.

The block also drives one shared chip-select line. A 4-bit enable mask picks which of the program, data, byte and I/O strobes may drive that line. The line is the combinational OR of the enabled strobes, so it has the same timing as the strobe it follows. All settings are written through a small register port.

Top module: `iows_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and ack_o is 0. Every region's wait setting is 7 and the direct mapping is selected. The enable mask is program=1, data=1, byte=0, I/O=1.
- R2: An access uses the wait setting of the region given by io_addr_i[10:9]: 0x000-0x1FF is region 0, 0x200-0x3FF is region 1, 0x400-0x5FF is region 2 and 0x600-0x7FF is region 3.
- R3: With the mode bit at 0 (direct mapping), a setting of n gives n wait cycles.
- R4: With the mode bit at 1 (stretched mapping), a setting of n gives 2n+1 wait cycles, so a setting of 7 gives 15.
- R5: io_start_i is sampled on a rising edge while the block is idle. After that edge, ready_o stays 0 for exactly the wait count. It is then 1, with ack_o at 1 for exactly one cycle, and the block returns to idle.
- R6: A wait count of 0 keeps ready_o at 1 and raises ack_o in the first cycle after the accepting edge.
- R7: io_start_i has no effect from the accepting edge until the acknowledge cycle has passed. It neither restarts nor extends the running count, and it queues no second access.
- R8: cs_o is combinationally the OR of the strobes whose mask bit is 1, with no register on the path.
- R9: Register writes take effect when cfg_we_i is high on a rising edge. The register is chosen by cfg_sel_i: 0 selects the wait settings, 1 selects the mode, and 2 selects the mask.
  - Wait settings: region k is in cfg_wdata_i[3k+2:3k].
  - Mode: the mode bit is cfg_wdata_i[0].
  - Mask: cfg_wdata_i[11] enables I/O, [10] byte, [9] data and [8] program.
  - A cfg_sel_i value of 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | 12 | Register write data |
| io_start_i | input | 1 | I/O access start request |
| io_addr_i | input | 11 | I/O address |
| pm_sel_i | input | 1 | Program memory strobe, active high |
| dm_sel_i | input | 1 | Data memory strobe, active high |
| bm_sel_i | input | 1 | Byte memory strobe, active high |
| io_sel_i | input | 1 | I/O strobe, active high |
| ready_o | output | 1 | Low while the access is being stretched |
| ack_o | output | 1 | One-cycle end-of-access pulse |
| cs_o | output | 1 | Composite chip select |

## Verification
Accesses go to both the first and the last word of each region. Each region holds a different setting, so a wrong decode of bits 10:9 gives a wait length that does not match. The same settings are run under both mappings. This separates n from 2n+1 and makes a count that is off by one or has a lost bit visible. The settings 0 and 7 under the stretched mapping exercise the extremes of 1 and 15 cycles. A restart request made in the middle of a count separates ignoring the request from restarting or queuing. Several masks, each driven with single strobes, show which strobe reaches cs_o.

// File: rtl/iows_pkg.sv
package iows_pkg;
  localparam int ADDR_W  = 11;
  localparam int REG_N   = 4;
  localparam int RSEL_W  = $clog2(REG_N);
  localparam int WS_W    = 3;
  localparam int CNT_W   = WS_W + 1;
  localparam int CFG_W   = REG_N * WS_W;
  localparam int MASK_W  = 4;
  localparam int MASK_LSB = 8;

  typedef enum logic [1:0] {
    CFG_WAITS = 2'd0,
    CFG_MODE  = 2'd1,
    CFG_MASK  = 2'd2
  } cfg_sel_e;

  // mask bit order: program, data, byte, io
  localparam logic [MASK_W-1:0] MASK_RST = 4'b1011;
  localparam logic [WS_W-1:0]   WS_RST   = '1;
endpackage

// File: rtl/iows_cfg_regs.sv
module iows_cfg_regs
  import iows_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [1:0]              sel_i,
  input  logic [CFG_W-1:0]        wdata_i,
  output logic [REG_N*WS_W-1:0]   waits_o,
  output logic                    mode_o,
  output logic [MASK_W-1:0]       mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waits_o <= {REG_N{WS_RST}};
      mode_o  <= 1'b0;
      mask_o  <= MASK_RST;
    end else if (we_i) begin
      unique case (sel_i)
        CFG_WAITS: waits_o <= wdata_i;
        CFG_MODE:  mode_o  <= wdata_i[0];
        CFG_MASK:  mask_o  <= wdata_i[MASK_LSB +: MASK_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iows_region_wait.sv
module iows_region_wait
  import iows_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_N*WS_W-1:0] waits_i,
  input  logic                  mode_i,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam int IDX_W = $clog2(REG_N);

  logic [WS_W-1:0]  field [REG_N];
  logic [IDX_W-1:0] idx;
  logic [WS_W-1:0]  sel_ws;

  for (genvar g = 0; g < REG_N; g++) begin : g_field
    assign field[g] = waits_i[g*WS_W +: WS_W];
  end

  assign idx    = addr_i[ADDR_W-1 -: IDX_W];
  assign sel_ws = field[idx];
  assign cnt_o  = mode_i ? {sel_ws, 1'b1} : {1'b0, sel_ws};

  p_alt_odd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> cnt_o[0]);
  p_direct_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> !cnt_o[CNT_W-1]);
endmodule

// File: rtl/iows_wait_timer.sv
module iows_wait_timer
  import iows_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ready_o,
  output logic             ack_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= cnt_i;
      end
    end else if (cnt_q == '0) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = !(active_q && cnt_q != '0);
  assign ack_o   = active_q && cnt_q == '0;

  p_ack_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ready_o);
  p_ack_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_wait_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (ready_o ? ack_o : !ack_o));
endmodule

// File: rtl/iows_ctrl.sv
module iows_ctrl
  import iows_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              io_start_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              pm_sel_i,
  input  logic              dm_sel_i,
  input  logic              bm_sel_i,
  input  logic              io_sel_i,
  output logic              ready_o,
  output logic              ack_o,
  output logic              cs_o
);
  logic [REG_N*WS_W-1:0] waits;
  logic                  mode;
  logic [MASK_W-1:0]     mask;
  logic [CNT_W-1:0]      cnt;
  logic [MASK_W-1:0]     strobes;

  iows_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .waits_o(waits), .mode_o(mode), .mask_o(mask)
  );

  iows_region_wait u_dec (
    .clk_i, .rst_ni,
    .addr_i(io_addr_i), .waits_i(waits), .mode_i(mode), .cnt_o(cnt)
  );

  iows_wait_timer u_tmr (
    .clk_i, .rst_ni,
    .start_i(io_start_i), .cnt_i(cnt), .ready_o, .ack_o
  );

  assign strobes = {io_sel_i, bm_sel_i, dm_sel_i, pm_sel_i};
  assign cs_o    = |(strobes & mask);

  p_cs_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobes == '0) |-> !cs_o);
  p_cs_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> (strobes != '0));
endmodule

// File: tb/sim_iows_ctrl.sv
module sim_iows_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [11:0] cfg_wdata = '0;
  logic io_start = 1'b0;
  logic [10:0] io_addr = '0;
  logic pm = 0, dm = 0, bm = 0, io = 0;
  logic ready, ack, cs;
  int errors = 0, checks = 0;
  bit done = 0;

  iows_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .io_start_i(io_start), .io_addr_i(io_addr),
    .pm_sel_i(pm), .dm_sel_i(dm), .bm_sel_i(bm), .io_sel_i(io),
    .ready_o(ready), .ack_o(ack), .cs_o(cs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [11:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_waits(input int r0, r1, r2, r3);
    wr(2'd0, 12'((r3 << 9) | (r2 << 6) | (r1 << 3) | r0));
  endtask

  // one access; returns measured low cycles, checks ack shape
  task automatic access(input string req, input logic [10:0] a, input int exp_n);
    int low = 0;
    @(negedge clk); io_start = 1; io_addr = a;
    @(negedge clk); io_start = 0;
    for (int i = 0; i < 40 && !ready; i++) begin
      if (ack) low = 99;
      low++;
      @(negedge clk);
    end
    chk(req, low, exp_n);
    chk({req, " ack"}, int'(ack), 1);
    @(negedge clk);
    chk({req, " ack single"}, int'(ack), 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", int'(ready), 1);
    chk("R1 ack", int'(ack), 0);
    pm = 1; #1 chk("R1 mask pm", int'(cs), 1); pm = 0;
    dm = 1; #1 chk("R1 mask dm", int'(cs), 1); dm = 0;
    bm = 1; #1 chk("R1 mask bm", int'(cs), 0); bm = 0;
    io = 1; #1 chk("R1 mask io", int'(cs), 1); io = 0;
    access("R1 default waits", 11'h400, 7);
  endtask

  task automatic t_direct;
    wr(2'd1, 12'd0);
    set_waits(1, 3, 0, 5);
    access("R2 R3 region0 low", 11'h000, 1);
    access("R2 R3 region0 high", 11'h1FF, 1);
    access("R2 R3 region1 low", 11'h200, 3);
    access("R2 R3 region1 high", 11'h3FF, 3);
    access("R6 region2 zero", 11'h400, 0);
    access("R2 R3 region3 low", 11'h600, 5);
    access("R2 R3 region3 high", 11'h7FF, 5);
  endtask

  task automatic t_stretch;
    wr(2'd1, 12'd1);
    access("R4 region0", 11'h010, 3);
    access("R4 region1", 11'h250, 7);
    access("R4 region2 zero", 11'h5FF, 1);
    access("R4 region3", 11'h700, 11);
    set_waits(7, 0, 0, 0);
    access("R4 max", 11'h001, 15);
    wr(2'd3, 12'hFFF);
    access("R9 sel3 no effect", 11'h001, 15);
    wr(2'd1, 12'd0);
  endtask

  task automatic t_busy;
    int low = 0;
    set_waits(5, 2, 0, 0);
    @(negedge clk); io_start = 1; io_addr = 11'h000;
    @(negedge clk); io_start = 0;
    @(negedge clk); io_start = 1; io_addr = 11'h400;
    @(negedge clk); io_start = 0;
    low = 2;
    while (!ready && low < 40) begin low++; @(negedge clk); end
    chk("R7 not restarted", low, 5);
    chk("R7 ack", int'(ack), 1);
    io_start = 1; io_addr = 11'h200;
    @(negedge clk); io_start = 0;
    chk("R7 no accept at ack", int'(ready) + int'(ack), 1);
    @(negedge clk);
    chk("R7 nothing queued", int'(ack), 0);
  endtask

  task automatic t_mask;
    wr(2'd2, 12'b0100_0000_0000);
    bm = 1; #1 chk("R8 R9 byte only", int'(cs), 1); bm = 0;
    io = 1; pm = 1; dm = 1; #1 chk("R8 R9 others off", int'(cs), 0);
    io = 0; pm = 0; dm = 0;
    wr(2'd2, 12'b0001_0000_0000);
    pm = 1; #1 chk("R8 pm on", int'(cs), 1);
    pm = 0; #1 chk("R8 follows strobe", int'(cs), 0);
    wr(2'd2, 12'd0);
    pm = 1; dm = 1; bm = 1; io = 1; #1 chk("R8 all masked", int'(cs), 0);
    pm = 0; dm = 0; bm = 0; io = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_direct;
    t_stretch;
    t_busy;
    t_mask;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule